// File: doc/BRIEF.md
# DAC Power Ramp Profile Sequencer

This block keeps a 64-entry table of 10-bit levels and plays it out to an auxiliary DAC, so that the power of an external RF amplifier rises and falls along a shape chosen by software. Playback moves one entry for each pulse of an internal sample-rate enable. It can make one pass and stop, or repeat. It can also sweep up to the top entry and back down to the bottom. A change of sweep mode waits until the sweep in progress has finished. When table playback is not selected, the DAC takes its level from a static register.

The host reaches the table through a window of four byte addresses. One pass through the window moves two table words. For each word, a byte carrying the two low bits comes first and a byte carrying the upper eight bits follows. An access pointer advances by two words on the last byte of the window. A control bit picks whether reads or writes are the accesses that advance it.

The DAC output is a level that the converter samples continuously. It has no valid/ready handshake, and back-pressure does not apply to it. The host side uses plain single-cycle byte strobes.

Top module: `ramp_profile_seq`

## Requirements
- R1: After reset, dac_out is 0, scan_done is 0 and the control register (address 4) reads 0.
- R2: Address 0 (word A) and address 2 (word B) hold a word's two low bits in data bits [1:0] and read back with bits [7:2] as zero. Address 1 (A) and address 3 (B) hold bits [9:2]. A word changes only when its upper byte is written, taking the low bits most recently written to its partner address. Word A is the word at the pointer, and word B is the word at the pointer plus one.
- R3: An access to address 3 advances the access pointer by two words. With control bit 7 at 0 only writes advance it; with bit 7 at 1 only reads do.
- R4: While control bit 6 is 0 the access pointer is held at word 0.
- R5: The access pointer wraps from the pair 62/63 to word 0.
- R6: With control bit 0 at 0, dac_out shows the static level, whose low bits are written at address 5 and whose upper byte is written at address 6 (the upper-byte write commits). With bit 0 at 1, dac_out shows the table entry at the playback pointer.
- R7: Setting bit 0 starts playback at entry 0, and each sample_tick moves it by one entry. In single mode (bit 2 at 0) without sweep-back (bit 1 at 0), a tick at entry 63 sets scan_done and holds entry 63.
- R8: With bit 1 at 1, playback climbs to entry 63 and then descends. A sweep ends on the tick that returns it to entry 0, and in single mode scan_done then rises.
- R9: With bit 2 at 1, playback repeats without end: a tick at entry 63 returns to entry 0 when bit 1 is 0. scan_done stays low.
- R10: A change to bits 1 or 2 during playback takes effect only at the end of the current sweep. A write in the very cycle of the sweep-ending tick counts toward the next sweep end, not this one.
- R11: While bit 0 is 1, window reads return 0, window writes are dropped and the access pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Byte write strobe |
| host_rd | input | 1 | Byte read strobe (only advances the pointer) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| sample_tick | input | 1 | Playback step enable |
| dac_out | output | 10 | Level sent to the auxiliary DAC |
| scan_done | output | 1 | Single-mode playback finished |

## Verification
The sweep-ending tick and a host write of new mode bits to the control register can land on the same clock edge. The bench provokes this by raising sample_tick and the control write together while the playback pointer sits on the last entry of a sweep. Both the deferred change and this collision are judged only through dac_out. The bench follows where the next sweep turns and checks whether it turns at entry 63 or wraps there, which shows whether the mode in force was the old one or the new one.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int HOST_W  = 8;
  localparam int HADDR_W = 3;

  // register addresses
  localparam logic [HADDR_W-1:0] RA_A_LO  = 3'd0;
  localparam logic [HADDR_W-1:0] RA_A_HI  = 3'd1;
  localparam logic [HADDR_W-1:0] RA_B_LO  = 3'd2;
  localparam logic [HADDR_W-1:0] RA_B_HI  = 3'd3;
  localparam logic [HADDR_W-1:0] RA_CTRL  = 3'd4;
  localparam logic [HADDR_W-1:0] RA_ST_LO = 3'd5;
  localparam logic [HADDR_W-1:0] RA_ST_HI = 3'd6;

  // control bit positions
  localparam int CB_SRC    = 0;
  localparam int CB_BOUNCE = 1;
  localparam int CB_CONT   = 2;
  localparam int CB_PTR_EN = 6;
  localparam int CB_RD_ADV = 7;
endpackage

// File: rtl/rps_access_ptr.sv
module rps_access_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] PAIR = AW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (!enable) ptr <= '0;
    else if (step)    ptr <= ptr + PAIR;
  end
endmodule

// File: rtl/rps_table.sv
module rps_table
  import rps_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [HADDR_W-1:0] addr,
  input  logic [HOST_W-1:0]  wdata,
  input  logic               lock,
  input  logic               ptr_en,
  input  logic               rd_adv,
  input  logic [AW-1:0]      play_ptr,
  output logic [HOST_W-1:0]  rdata,
  output logic [DW-1:0]      play_data,
  output logic [AW-1:0]      acc_ptr
);
  localparam int LOW_W = DW - HOST_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [LOW_W-1:0] stage_a, stage_b;
  logic [AW-1:0]    word_a, word_b;
  logic             in_win, wr_ok, step;

  assign in_win = (addr[HADDR_W-1] == 1'b0);
  assign wr_ok  = wr && in_win && !lock;
  assign step   = !lock && (addr == RA_B_HI) && (rd_adv ? rd : wr);
  assign word_a = acc_ptr;
  assign word_b = acc_ptr + AW'(1);

  rps_access_ptr #(.AW(AW)) u_aptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ptr_en),
    .step   (step),
    .ptr    (acc_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_a <= '0;
      stage_b <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      case (addr)
        RA_A_LO: stage_a      <= wdata[LOW_W-1:0];
        RA_A_HI: mem[word_a]  <= {wdata, stage_a};
        RA_B_LO: stage_b      <= wdata[LOW_W-1:0];
        RA_B_HI: mem[word_b]  <= {wdata, stage_b};
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (in_win && !lock) begin
      case (addr)
        RA_A_LO: rdata[LOW_W-1:0] = mem[word_a][LOW_W-1:0];
        RA_A_HI: rdata            = mem[word_a][DW-1:LOW_W];
        RA_B_LO: rdata[LOW_W-1:0] = mem[word_b][LOW_W-1:0];
        RA_B_HI: rdata            = mem[word_b][DW-1:LOW_W];
        default: ;
      endcase
    end
  end

  assign play_data = mem[play_ptr];
endmodule

// File: rtl/rps_player.sv
module rps_player #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          bounce_req,
  input  logic          cont_req,
  output logic [AW-1:0] ptr,
  output logic          done
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic dir_down, fresh, act_b, act_c, eff_b, eff_c;

  // before the first step the requested mode is live; afterwards latched
  assign eff_b = fresh ? bounce_req : act_b;
  assign eff_c = fresh ? cont_req   : act_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; dir_down <= 1'b0; done <= 1'b0;
      fresh <= 1'b1; act_b <= 1'b0; act_c <= 1'b0;
    end else if (!run) begin
      ptr <= '0; dir_down <= 1'b0; done <= 1'b0; fresh <= 1'b1;
    end else if (tick && !done) begin
      fresh <= 1'b0;
      act_b <= eff_b;
      act_c <= eff_c;
      if (!eff_b) begin
        if (ptr == TOP) begin
          if (eff_c) begin
            ptr <= '0;
            act_b <= bounce_req;
            act_c <= cont_req;
          end else begin
            done <= 1'b1;
          end
        end else begin
          ptr <= ptr + AW'(1);
        end
      end else if (!dir_down) begin
        if (ptr == TOP) begin
          dir_down <= 1'b1;
          ptr <= ptr - AW'(1);
        end else begin
          ptr <= ptr + AW'(1);
        end
      end else if (ptr == AW'(1)) begin
        ptr <= '0;
        dir_down <= 1'b0;
        if (eff_c) begin
          act_b <= bounce_req;
          act_c <= cont_req;
        end else begin
          done <= 1'b1;
        end
      end else begin
        ptr <= ptr - AW'(1);
      end
    end
  end
endmodule

// File: rtl/ramp_profile_seq.sv
module ramp_profile_seq
  import rps_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0]  host_wdata,
  output logic [HOST_W-1:0]  host_rdata,
  input  logic               sample_tick,
  output logic [DW-1:0]      dac_out,
  output logic               scan_done
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LOW_W = DW - HOST_W;

  logic [HOST_W-1:0] ctrl_q;
  logic [LOW_W-1:0]  st_stage;
  logic [DW-1:0]     static_lvl, play_data;
  logic [HOST_W-1:0] win_rdata;
  logic [AW-1:0]     play_ptr, acc_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; st_stage <= '0; static_lvl <= '0;
    end else if (host_wr) begin
      case (host_addr)
        RA_CTRL:  ctrl_q     <= host_wdata;
        RA_ST_LO: st_stage   <= host_wdata[LOW_W-1:0];
        RA_ST_HI: static_lvl <= {host_wdata, st_stage};
        default: ;
      endcase
    end
  end

  rps_table #(.DEPTH(DEPTH), .DW(DW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (host_wr),
    .rd        (host_rd),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .lock      (ctrl_q[CB_SRC]),
    .ptr_en    (ctrl_q[CB_PTR_EN]),
    .rd_adv    (ctrl_q[CB_RD_ADV]),
    .play_ptr  (play_ptr),
    .rdata     (win_rdata),
    .play_data (play_data),
    .acc_ptr   (acc_ptr)
  );

  rps_player #(.DEPTH(DEPTH)) u_player (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q[CB_SRC]),
    .tick       (sample_tick),
    .bounce_req (ctrl_q[CB_BOUNCE]),
    .cont_req   (ctrl_q[CB_CONT]),
    .ptr        (play_ptr),
    .done       (scan_done)
  );

  always_comb begin
    host_rdata = win_rdata;
    case (host_addr)
      RA_CTRL:  host_rdata = ctrl_q;
      RA_ST_LO: host_rdata = {{(HOST_W-LOW_W){1'b0}}, static_lvl[LOW_W-1:0]};
      RA_ST_HI: host_rdata = static_lvl[DW-1:LOW_W];
      3'd7:     host_rdata = '0;
      default: ;
    endcase
  end

  assign dac_out = ctrl_q[CB_SRC] ? play_data : static_lvl;
endmodule

// File: rtl/ramp_profile_seq_checker.sv
module ramp_profile_seq_checker #(
  parameter int AW = 6,
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic [2:0]    host_addr,
  input logic          sample_tick,
  input logic [7:0]    ctrl_q,
  input logic [AW-1:0] acc_ptr,
  input logic [AW-1:0] play_ptr,
  input logic [DW-1:0] dac_out,
  input logic          scan_done
);
  logic ctrl_wr;
  assign ctrl_wr = host_wr && (host_addr == 3'd4);

  a_r4_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[6] && !ctrl_wr) |=> (acc_ptr == '0));

  a_r3_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd3 && ctrl_q[6] && !ctrl_q[7] && !ctrl_q[0])
      |=> (acc_ptr == $past(acc_ptr) + AW'(2)));

  a_r3_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_addr == 3'd3 && ctrl_q[6] && ctrl_q[7] && !ctrl_q[0])
      |=> (acc_ptr == $past(acc_ptr) + AW'(2)));

  a_r11_locked_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && ctrl_q[6] && !ctrl_wr) |=> $stable(acc_ptr));

  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !sample_tick && !ctrl_wr) |=> $stable(play_ptr));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && ctrl_q[0] && !ctrl_wr) |=> (scan_done && $stable(dac_out)));

  a_r8_unit_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && sample_tick && !scan_done && !ctrl_wr)
      |=> (play_ptr == $past(play_ptr) + AW'(1) || play_ptr == $past(play_ptr) - AW'(1)
           || play_ptr == '0 || scan_done));
endmodule

bind ramp_profile_seq ramp_profile_seq_checker #(.AW(AW), .DW(DW)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .sample_tick (sample_tick),
  .ctrl_q      (ctrl_q),
  .acc_ptr     (acc_ptr),
  .play_ptr    (play_ptr),
  .dac_out     (dac_out),
  .scan_done   (scan_done)
);

// File: tb/ramp_profile_seq_test.sv
`timescale 1ns/1ps
module ramp_profile_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, sample_tick = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [9:0] dac_out;
  logic       scan_done;

  int checks = 0, fails = 0;
  logic [9:0] exp_mem [64];

  always #2.5 clk = ~clk;

  ramp_profile_seq uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sample_tick(sample_tick), .dac_out(dac_out), .scan_done(scan_done)
  );

  // vector: {tag R3?, read?, addr[2:0], wdata[7:0], expect[7:0]}
  localparam int NV = 21;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd4, 8'h40, 8'h00},
    {1'b0, 1'b0, 3'd0, 8'h03, 8'h00},
    {1'b0, 1'b0, 3'd1, 8'hAA, 8'h00},
    {1'b0, 1'b0, 3'd2, 8'hFD, 8'h00},
    {1'b1, 1'b0, 3'd3, 8'h55, 8'h00},
    {1'b0, 1'b0, 3'd4, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd4, 8'hC0, 8'h00},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h03},
    {1'b0, 1'b1, 3'd1, 8'h00, 8'hAA},
    {1'b0, 1'b1, 3'd2, 8'h00, 8'h01},
    {1'b1, 1'b1, 3'd3, 8'h00, 8'h55},
    {1'b1, 1'b1, 3'd1, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd0, 8'h02, 8'h00},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd1, 8'h11, 8'h00},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h02},
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h11},
    {1'b1, 1'b0, 3'd3, 8'h77, 8'h00},
    {1'b1, 1'b1, 3'd3, 8'h00, 8'h77},
    {1'b1, 1'b1, 3'd3, 8'h00, 8'h00},
    {1'b0, 1'b1, 3'd4, 8'h00, 8'hC0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #1 check(req, host_rdata, e);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
    end
  endtask

  task automatic dac_is(input string req, input int idx);
    #1 check(req, dac_out, exp_mem[idx]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 10'((i * 37 + 3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1", dac_out, 0);
    check("R1", scan_done, 0);
    rd("R1", 3'd4, 8'h00);

    // vector walk: R2 / R3 window behaviour
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rd(VEC[i][20] ? "R3" : "R2", VEC[i][18:16], VEC[i][7:0]);
      else wr(VEC[i][18:16], VEC[i][15:8]);
    end

    // R4: pointer held at zero while bit 6 low
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h01); wr(3'd1, 8'h10); wr(3'd2, 8'h00); wr(3'd3, 8'h20);
    wr(3'd1, 8'h30);
    wr(3'd4, 8'hC0);
    rd("R4", 3'd1, 8'h30);
    rd("R4", 3'd3, 8'h20);

    // fill table, then one extra pass exercises the wrap (R5)
    wr(3'd4, 8'h00); wr(3'd4, 8'h40);
    for (int p = 0; p < 32; p++) begin
      wr(3'd0, 8'(exp_mem[2*p][1:0]));   wr(3'd1, exp_mem[2*p][9:2]);
      wr(3'd2, 8'(exp_mem[2*p+1][1:0])); wr(3'd3, exp_mem[2*p+1][9:2]);
    end
    exp_mem[0] = 10'h3FF;
    wr(3'd0, 8'h03); wr(3'd1, 8'hFF);
    wr(3'd4, 8'h00); wr(3'd4, 8'hC0);
    rd("R5", 3'd1, 8'hFF);
    rd("R5", 3'd0, 8'h03);

    // R11: window locked during playback
    wr(3'd4, 8'h00); wr(3'd4, 8'h41);
    rd("R11", 3'd1, 8'h00);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'hC0);
    rd("R11", 3'd1, exp_mem[0][9:2]);
    rd("R11", 3'd3, exp_mem[1][9:2]);

    // R6: DAC source select
    wr(3'd5, 8'h02); wr(3'd6, 8'h80); wr(3'd4, 8'h00);
    #1 check("R6", dac_out, 10'h202);
    wr(3'd4, 8'h01);
    dac_is("R6", 0);

    // R7: single pass, no sweep-back
    for (int k = 1; k < 64; k++) begin
      ticks(1);
      dac_is("R7", k);
    end
    check("R7", scan_done, 0);
    ticks(1);
    check("R7", scan_done, 1);
    dac_is("R7", 63);
    ticks(1);
    dac_is("R7", 63);

    // R8: single pass with sweep-back
    wr(3'd4, 8'h00); wr(3'd4, 8'h03);
    ticks(64);
    dac_is("R8", 62);
    ticks(61);
    dac_is("R8", 1);
    check("R8", scan_done, 0);
    ticks(1);
    dac_is("R8", 0);
    check("R8", scan_done, 1);

    // R9: continuous, wrap at top
    wr(3'd4, 8'h00); wr(3'd4, 8'h05);
    ticks(63);
    dac_is("R9", 63);
    ticks(1);
    dac_is("R9", 0);
    check("R9", scan_done, 0);
    ticks(1);
    dac_is("R9", 1);

    // R10: mode change mid-sweep deferred to the sweep end
    wr(3'd4, 8'h00); wr(3'd4, 8'h05);
    ticks(10);
    wr(3'd4, 8'h07);
    ticks(53);
    dac_is("R10", 63);
    ticks(1);
    dac_is("R10", 0);        // old mode finished this sweep
    ticks(63);
    ticks(1);
    dac_is("R10", 62);       // new mode now turns at the top
    ticks(61);
    dac_is("R10", 1);
    // collision: control write on the sweep-ending tick
    @(negedge clk); host_wr = 1'b1; host_addr = 3'd4; host_wdata = 8'h05; sample_tick = 1'b1;
    @(negedge clk); host_wr = 1'b0; sample_tick = 1'b0;
    dac_is("R10", 0);
    ticks(63);
    ticks(1);
    dac_is("R10", 62);       // still sweeping back: write not yet applied
    ticks(62);
    dac_is("R10", 0);
    ticks(63);
    ticks(1);
    dac_is("R10", 0);        // applied: wraps at the top

    finish_run();
  end
endmodule